// File: doc/BRIEF.md
# Event Counter Decimal Line Streamer

This block holds a 32-bit event count and reports it to a host as lines of text over an 8-bit parallel byte FIFO. Each line carries the count in decimal ASCII and ends with a newline. At the start of a line the block copies the count into a converter. The converter turns the binary value into ten BCD digits with a sequential shift-and-add-three loop that runs one bit per clock. The resulting characters go into a line buffer. Bytes are handed to the FIFO one at a time. The most significant digit goes first, and leading zeros are kept.

Flow control is a write strobe paced by the FIFO's active-low space flag. A byte counts as taken only on a rising clock edge where `wr_stb` is high and `space_n` is low. While `space_n` stays high the block holds the strobe and the byte unchanged, for as many cycles as the stall lasts. After every accepted byte the strobe drops for one cycle before the next byte appears. `space_n` has no effect while the strobe is low.

When the newline is accepted, the count advances by one and a new conversion starts from the new value. An LED bus shows the top byte of the count. The FIFO's read strobe is held inactive.

Top module: `dec_line_streamer`

## Requirements
- R1: While reset is asserted and just after it, `wr_stb` is 0, `rd_stb_n` is 1 and `led` equals bits 31..24 of `CNT_INIT`.
- R2: Every line is exactly 11 accepted bytes. Byte positions 0..9 are ASCII digits (0x30 plus the digit value) and position 10 is the newline 0x0A.
- R3: The ten digits are the decimal value of the line's count, most significant digit at position 0, with leading zeros kept.
- R4: While `wr_stb` is high and `space_n` is sampled high, `wr_stb` stays high and `tx_byte` keeps its value on the next cycle. A byte is accepted only on an edge where both `wr_stb` is high and `space_n` is low.
- R5: In the cycle after an accepted byte, `wr_stb` is low.
- R6: The first line carries `CNT_INIT`. Each completed line advances the count by one modulo 2^32, so 4294967295 is followed by 0.
- R7: After the newline is accepted, `wr_stb` stays low for exactly CNT_W+2 = 34 cycles (snapshot, 32 conversion steps, buffer load) before the next line's first byte is offered. `space_n` has no effect during this time.
- R8: `led` shows bits 31..24 of the count on the line being sent. It changes only after a newline has been accepted.
- R9: `rd_stb_n` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| space_n | input | 1 | FIFO has room when low |
| wr_stb | output | 1 | High while a byte is offered |
| tx_byte | output | 8 | Offered character |
| rd_stb_n | output | 1 | FIFO read strobe, held high |
| led | output | 8 | Top byte of the event count |

## Verification
The count starts at 4294967293, so the first lines cover the largest ten-digit values and the wrap to zero. The later lines are small values with many leading zeros, which separates digit-order and padding faults from conversion faults. The FIFO flag is driven in three patterns: always ready, fair coin flips, and mostly full. Always-ready traffic exposes timing of the strobe gap and of the conversion. Coin flips and long stalls show whether a byte moves or changes without being accepted. The flag is also toggled during conversion, which shows that it is ignored while no byte is offered.

// File: rtl/dls_pkg.sv
package dls_pkg;
  // upper nibble of an ASCII decimal digit
  localparam logic [3:0] CHR_DIGIT_HI = 4'h3;
  localparam logic [7:0] CHR_NEWLINE  = 8'h0A;
  // shift-and-add-three correction
  localparam logic [3:0] BCD_ADJ_MIN  = 4'd5;
  localparam logic [3:0] BCD_ADJ_ADD  = 4'd3;
endpackage

// File: rtl/dls_bcd_adjust.sv
module dls_bcd_adjust #(
  parameter int unsigned DIGITS = 10,
  parameter int unsigned BCD_W  = 4 * DIGITS
) (
  input  logic [BCD_W-1:0] bcd_in,
  output logic [BCD_W-1:0] bcd_out
);
  import dls_pkg::*;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] nib;
    assign nib = bcd_in[4*g +: 4];
    assign bcd_out[4*g +: 4] = (nib >= BCD_ADJ_MIN) ? nib + BCD_ADJ_ADD : nib;
  end
endmodule

// File: rtl/dls_bcd_conv.sv
module dls_bcd_conv #(
  parameter int unsigned BIN_W  = 32,
  parameter int unsigned DIGITS = 10,
  parameter int unsigned BCD_W  = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BIN_W-1:0] bin_in,
  output logic [BCD_W-1:0] bcd_out,
  output logic             done
);
  localparam int unsigned    ITER_W    = $clog2(BIN_W) + 1;
  localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(BIN_W - 1);
  localparam logic [ITER_W-1:0] ITER_ONE  = ITER_W'(1);

  logic [BIN_W-1:0]  shadow;
  logic [BCD_W-1:0]  bcd_q;
  logic [BCD_W-1:0]  bcd_adj;
  logic [ITER_W-1:0] iter;
  logic              busy;

  dls_bcd_adjust #(.DIGITS(DIGITS), .BCD_W(BCD_W)) u_adj (
    .bcd_in (bcd_q),
    .bcd_out(bcd_adj)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      bcd_q  <= '0;
      iter   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shadow <= bin_in;
        bcd_q  <= '0;
        iter   <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        // one bit per cycle: correct digits, then shift in the next binary bit
        bcd_q  <= {bcd_adj[BCD_W-2:0], shadow[BIN_W-1]};
        shadow <= {shadow[BIN_W-2:0], 1'b0};
        iter   <= iter + ITER_ONE;
        if (iter == LAST_ITER) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign bcd_out = bcd_q;
endmodule

// File: rtl/dls_tx_shift.sv
module dls_tx_shift #(
  parameter int unsigned DIGITS = 10,
  parameter int unsigned BCD_W  = 4 * DIGITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [BCD_W-1:0] bcd,
  input  logic             space_n,
  output logic             wr_stb,
  output logic [7:0]       tx_byte,
  output logic             line_done
);
  import dls_pkg::*;

  localparam int unsigned LINE_BYTES = DIGITS + 1;
  localparam int unsigned LINE_W     = 8 * LINE_BYTES;
  localparam int unsigned IDX_W      = $clog2(LINE_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  logic [LINE_W-1:0] line_q;
  logic [LINE_W-1:0] line_img;
  logic [IDX_W-1:0]  idx;
  logic              active;
  logic              commit;

  // digits most significant first, newline in the lowest byte
  always_comb begin
    line_img = '0;
    for (int i = 0; i < DIGITS; i++) begin
      line_img[LINE_W-1-8*i -: 8] = {CHR_DIGIT_HI, bcd[BCD_W-1-4*i -: 4]};
    end
    line_img[7:0] = CHR_NEWLINE;
  end

  assign commit    = wr_stb & ~space_n;
  assign line_done = commit & (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      idx    <= '0;
      active <= 1'b0;
      wr_stb <= 1'b0;
    end else if (load) begin
      line_q <= line_img;
      idx    <= '0;
      active <= 1'b1;
      wr_stb <= 1'b1;
    end else if (commit) begin
      wr_stb <= 1'b0;
      if (idx == LAST_IDX) begin
        active <= 1'b0;
      end else begin
        line_q <= {line_q[LINE_W-9:0], 8'h00};
        idx    <= idx + IDX_ONE;
      end
    end else if (active && !wr_stb) begin
      wr_stb <= 1'b1;
    end
  end

  assign tx_byte = line_q[LINE_W-1 -: 8];
endmodule

// File: rtl/dec_line_streamer.sv
module dec_line_streamer #(
  parameter int unsigned      CNT_W    = 32,
  parameter int unsigned      DIGITS   = 10,  // 10**DIGITS must exceed 2**CNT_W
  parameter int unsigned      LED_W    = 8,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             space_n,
  output logic             wr_stb,
  output logic [7:0]       tx_byte,
  output logic             rd_stb_n,
  output logic [LED_W-1:0] led
);
  localparam int unsigned      BCD_W   = 4 * DIGITS;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] evt_cnt;
  logic             kick;
  logic             conv_done;
  logic             line_done;
  logic [BCD_W-1:0] bcd;

  // kick starts a conversion one cycle after the count has settled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cnt <= CNT_INIT;
      kick    <= 1'b1;
    end else begin
      kick <= line_done;
      if (line_done) evt_cnt <= evt_cnt + CNT_ONE;
    end
  end

  dls_bcd_conv #(.BIN_W(CNT_W), .DIGITS(DIGITS), .BCD_W(BCD_W)) u_conv (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (kick),
    .bin_in (evt_cnt),
    .bcd_out(bcd),
    .done   (conv_done)
  );

  dls_tx_shift #(.DIGITS(DIGITS), .BCD_W(BCD_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (conv_done),
    .bcd      (bcd),
    .space_n  (space_n),
    .wr_stb   (wr_stb),
    .tx_byte  (tx_byte),
    .line_done(line_done)
  );

  assign rd_stb_n = 1'b1;
  assign led      = evt_cnt[CNT_W-1 -: LED_W];
endmodule

// File: rtl/dls_chk.sv
module dls_chk #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned LED_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             space_n,
  input logic             wr_stb,
  input logic             rd_stb_n,
  input logic [7:0]       tx_byte,
  input logic [LED_W-1:0] led
);
  localparam int unsigned       MAX_LOW = CNT_W + 2;
  localparam int unsigned       RUN_W   = $clog2(MAX_LOW + 2) + 1;
  localparam logic [RUN_W-1:0]  RUN_ONE = RUN_W'(1);
  localparam logic [RUN_W-1:0]  RUN_MAX = RUN_W'(MAX_LOW);

  logic [RUN_W-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (wr_stb)         low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + RUN_ONE;
  end

  // R4
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && space_n) |=> (wr_stb && $stable(tx_byte)));

  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !space_n) |=> !wr_stb);

  // R7
  conv_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RUN_MAX);

  // R8
  led_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb || space_n) |=> $stable(led));

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_n);

  // R2
  char_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ((tx_byte >= 8'h30 && tx_byte <= 8'h39) || tx_byte == 8'h0A));
endmodule

bind dec_line_streamer dls_chk #(.CNT_W(CNT_W), .LED_W(LED_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .space_n (space_n),
  .wr_stb  (wr_stb),
  .rd_stb_n(rd_stb_n),
  .tx_byte (tx_byte),
  .led     (led)
);

// File: tb/dec_line_streamer_tb.sv
module dec_line_streamer_tb;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned DIGITS  = 10;
  localparam int unsigned LED_W   = 8;
  localparam logic [31:0] INIT    = 32'hFFFF_FFFD;
  localparam int          NLINES  = 40;
  localparam int          GAP_EXP = CNT_W + 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             space_n = 1'b1;
  logic             wr_stb;
  logic [7:0]       tx_byte;
  logic             rd_stb_n;
  logic [LED_W-1:0] led;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  dec_line_streamer #(.CNT_W(CNT_W), .DIGITS(DIGITS), .LED_W(LED_W), .CNT_INIT(INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .space_n(space_n), .wr_stb(wr_stb),
    .tx_byte(tx_byte), .rd_stb_n(rd_stb_n), .led(led)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference character at position pos of the line for value v
  function automatic logic [7:0] exp_char(input logic [31:0] v, input int pos);
    longint unsigned vv = longint'(v);
    longint unsigned p  = 1;
    if (pos == DIGITS) return 8'h0A;
    for (int k = 0; k < DIGITS - 1 - pos; k++) p = p * 10;
    return 8'h30 + 8'((vv / p) % 10);
  endfunction

  initial begin
    logic [31:0] val;
    int          line, bidx, low_cnt;
    bit          gap_checked, prev_commit, prev_stall;
    logic [7:0]  prev_byte;
    logic [7:0]  want;

    void'($urandom(32'd7351));
    val = INIT; line = 0; bidx = 0; low_cnt = 0;
    gap_checked = 0; prev_commit = 0; prev_stall = 0; prev_byte = '0;

    repeat (3) @(negedge clk);
    chk(wr_stb === 1'b0, "R1", "wr_stb in reset", longint'(wr_stb), 0);
    chk(rd_stb_n === 1'b1, "R1", "rd_stb_n in reset", longint'(rd_stb_n), 1);
    chk(led === INIT[31:24], "R1", "led in reset", longint'(led), longint'(INIT[31:24]));
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_stb === 1'b0, "R1", "wr_stb after reset", longint'(wr_stb), 0);

    for (int cyc = 0; cyc < 150000; cyc++) begin
      if (line >= NLINES) break;
      @(negedge clk);
      if (prev_commit)
        chk(wr_stb == 1'b0, "R5", "strobe after accept", longint'(wr_stb), 0);
      if (prev_stall) begin
        chk(wr_stb == 1'b1, "R4", "strobe held in stall", longint'(wr_stb), 1);
        chk(tx_byte == prev_byte, "R4", "byte held in stall", longint'(tx_byte), longint'(prev_byte));
      end
      if (!wr_stb) begin
        low_cnt++;
      end else begin
        if (bidx == 0 && !gap_checked) begin
          gap_checked = 1;
          if (line > 0)
            chk(low_cnt == GAP_EXP, "R7", "conversion gap", longint'(low_cnt), longint'(GAP_EXP));
          chk(led == val[31:24], "R8", "led for line", longint'(led), longint'(val[31:24]));
        end
        low_cnt = 0;
      end

      // flag pattern per phase: ready, coin flip, mostly full, mixed
      if (line < 4)       space_n = 1'b0;
      else if (line < 16) space_n = 1'($urandom % 2);
      else if (line < 28) space_n = (($urandom % 8) != 0);
      else                space_n = (($urandom % 4) == 0);

      prev_commit = wr_stb && !space_n;
      prev_stall  = wr_stb && space_n;
      prev_byte   = tx_byte;

      if (prev_commit) begin
        want = exp_char(val, bidx);
        if (bidx == DIGITS)
          chk(tx_byte == want, "R2", "newline byte", longint'(tx_byte), longint'(want));
        else
          chk(tx_byte == want, "R3/R6", $sformatf("digit %0d of line %0d", bidx, line),
              longint'(tx_byte), longint'(want));
        chk(rd_stb_n == 1'b1, "R9", "read strobe idle", longint'(rd_stb_n), 1);
        bidx++;
        if (bidx == DIGITS + 1) begin
          bidx = 0;
          line++;
          val = val + 32'd1;
          gap_checked = 0;
        end
      end
    end

    if (line < NLINES)
      chk(1'b0, "watchdog", "lines completed", longint'(line), longint'(NLINES));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule